// File: doc/BRIEF.md
# Row Tag Buffer for a Tags-in-Row DRAM Cache

In a DRAM cache that keeps each row's block tags inside the same DRAM row as the block data, finding out whether a request hits normally costs a DRAM metadata access before the data access itself. This block keeps a small fully associative SRAM buffer. Each entry is keyed by a DRAM row number and holds that row's complete group of block tags, with one valid bit per block. A lookup whose row is buffered is answered from SRAM one cycle after it is accepted.

When the row is not buffered, the block raises a metadata read for that row and holds the lookup. When the row's tags come back, it installs them over the least recently used entry and answers the lookup from the returned tags. Every response reports hit or miss, the index of the matching block, and whether a DRAM metadata access was needed. Only one lookup can be in flight at a time. A separate update port carries cache fills and evictions, and it patches the buffered copy of a row so the copy never goes stale.

Top module: `row_tag_buffer`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, meta_rd_valid is 0 and no row is buffered, so the first lookup of any row needs a metadata fetch.
- R2: A lookup accepted (req_valid and req_ready high at a clock edge) for a buffered row produces rsp_valid in the following cycle with rsp_fetched 0, and raises no metadata read.
- R3: A lookup hits when a block slot of its row has its valid bit set and a tag equal to req_tag. rsp_blk is the lowest such slot index. On a miss, rsp_hit is 0 and rsp_blk is 0.
- R4: A lookup accepted for an unbuffered row raises meta_rd_valid in the next cycle with meta_rd_row equal to the requested row. Both stay steady and req_ready stays low until meta_ret_valid is seen.
- R5: In the cycle meta_ret_valid is high during a fetch, the returned tags are installed. The response follows in the next cycle with rsp_fetched 1, and its hit and block are decided from the returned tags.
- R6: The buffer has ENTRIES (default 8) rows. Installing a row when all entries are in use replaces the least recently used row.
- R7: Both a buffered hit and an install make that row the most recently used.
- R8: An update (upd_valid) to a buffered row changes that row's slot upd_blk at the clock edge. upd_set 1 writes upd_tag and sets the slot valid; upd_set 0 clears the slot's valid bit. Lookups accepted in later cycles see the change without a fetch.
- R9: An update to a row that is not buffered is ignored: no entry changes, and a later lookup of that row fetches and uses the returned tags.
- R10: Returned metadata places slot i's tag at meta_ret_tags[i*TAG_W +: TAG_W] and its valid bit at meta_ret_vld[i]. A slot whose valid bit is 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted |
| req_row | input | ROW_W | DRAM row of the lookup |
| req_tag | input | TAG_W | Tag to search for |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_hit | output | 1 | Cache hit |
| rsp_blk | output | BLK_W | Matching block slot |
| rsp_fetched | output | 1 | A DRAM metadata read was needed |
| meta_rd_valid | output | 1 | Metadata read requested |
| meta_rd_row | output | ROW_W | Row whose tags are requested |
| meta_ret_valid | input | 1 | Returned metadata valid |
| meta_ret_tags | input | BLKS*TAG_W | Returned tags, slot i at i*TAG_W |
| meta_ret_vld | input | BLKS | Returned per-slot valid bits |
| upd_valid | input | 1 | Tag update valid |
| upd_row | input | ROW_W | Row being updated |
| upd_blk | input | BLK_W | Slot being updated |
| upd_tag | input | TAG_W | New tag for a fill |
| upd_set | input | 1 | 1 fill, 0 eviction |

## Verification
Lookups are tried on rows that are buffered, on rows that are absent, on rows whose tags repeat within the row, and on rows with invalid slots. This separates the fast path from the fetch path, and it also shows that the lowest-slot rule and the valid bits are respected. A run of installs beyond capacity, with a deliberate hit on the oldest row, separates true LRU replacement from replacement in plain fill order. Updates aimed at buffered rows and at absent rows, followed by lookups, show that the buffered copy is patched in one case and left untouched in the other. A pseudo-random phase then mixes hits, misses, evictions and updates against a reference model of row recency.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } rtb_state_e;
endpackage

// File: rtl/rtb_match.sv
module rtb_match #(
  parameter int TAG_W = 10,
  parameter int BLKS  = 3,
  parameter int BLK_W = (BLKS > 1) ? $clog2(BLKS) : 1
) (
  input  logic [BLKS*TAG_W-1:0] tags,
  input  logic [BLKS-1:0]       vld,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic [BLK_W-1:0]      blk
);
  logic [BLKS-1:0] eq;

  for (genvar b = 0; b < BLKS; b++) begin : g_cmp
    assign eq[b] = vld[b] && (tags[b*TAG_W +: TAG_W] == key);
  end

  // lowest matching slot wins
  always_comb begin
    hit = |eq;
    blk = '0;
    for (int b = BLKS - 1; b >= 0; b--) begin
      if (eq[b]) blk = BLK_W'(b);
    end
  end
endmodule

// File: rtl/rtb_entry_array.sv
module rtb_entry_array #(
  parameter int ENTRIES = 8,
  parameter int ROW_W   = 12,
  parameter int TAG_W   = 10,
  parameter int BLKS    = 3,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int BLK_W   = (BLKS > 1) ? $clog2(BLKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ROW_W-1:0]      lk_row,
  output logic                  lk_present,
  output logic [IDX_W-1:0]      lk_idx,
  output logic [BLKS*TAG_W-1:0] lk_tags,
  output logic [BLKS-1:0]       lk_vld,
  input  logic                  ins_en,
  input  logic [IDX_W-1:0]      ins_idx,
  input  logic [ROW_W-1:0]      ins_row,
  input  logic [BLKS*TAG_W-1:0] ins_tags,
  input  logic [BLKS-1:0]       ins_vld,
  input  logic                  upd_en,
  input  logic [ROW_W-1:0]      upd_row,
  input  logic [BLK_W-1:0]      upd_blk,
  input  logic [TAG_W-1:0]      upd_tag,
  input  logic                  upd_set,
  output logic [ENTRIES-1:0]    ent_used
);
  logic [ENTRIES-1:0]    ent_v, nx_v;
  logic [ROW_W-1:0]      ent_row  [ENTRIES];
  logic [ROW_W-1:0]      nx_row   [ENTRIES];
  logic [BLKS*TAG_W-1:0] ent_tags [ENTRIES];
  logic [BLKS*TAG_W-1:0] nx_tags  [ENTRIES];
  logic [BLKS-1:0]       ent_bv   [ENTRIES];
  logic [BLKS-1:0]       nx_bv    [ENTRIES];
  logic [ENTRIES-1:0]    lk_vec, up_vec, ent_we;
  logic                  upd_blk_ok;

  assign upd_blk_ok = (int'(upd_blk) < BLKS);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cam
    assign lk_vec[e] = ent_v[e] && (ent_row[e] == lk_row);
    assign up_vec[e] = ent_v[e] && (ent_row[e] == upd_row);
    assign ent_we[e] = (upd_en && upd_blk_ok && up_vec[e]) ||
                       (ins_en && (ins_idx == IDX_W'(e)));
  end

  always_comb begin
    lk_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_vec[e]) lk_idx = IDX_W'(e);
    end
  end

  assign lk_present = |lk_vec;
  assign lk_tags    = ent_tags[lk_idx];
  assign lk_vld     = ent_bv[lk_idx];
  assign ent_used   = ent_v;

  // next-state: an update patches a buffered copy, an install overrides it
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      nx_v[e]    = ent_v[e];
      nx_row[e]  = ent_row[e];
      nx_tags[e] = ent_tags[e];
      nx_bv[e]   = ent_bv[e];
      if (upd_en && upd_blk_ok && up_vec[e]) begin
        if (upd_set) begin
          nx_tags[e][int'(upd_blk)*TAG_W +: TAG_W] = upd_tag;
          nx_bv[e][upd_blk] = 1'b1;
        end else begin
          nx_bv[e][upd_blk] = 1'b0;
        end
      end
      if (ins_en && (ins_idx == IDX_W'(e))) begin
        nx_v[e]    = 1'b1;
        nx_row[e]  = ins_row;
        nx_tags[e] = ins_tags;
        nx_bv[e]   = ins_vld;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v <= '0;
    else        ent_v <= nx_v;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (ent_we[e]) begin
        ent_row[e]  <= nx_row[e];
        ent_tags[e] <= nx_tags[e];
        ent_bv[e]   <= nx_bv[e];
      end
    end
  end

  // R6: a row occupies at most one entry
  p_row_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec))
    else $error("row present in more than one entry");

  // R5: an install never targets a row that is already buffered
  p_install_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !(lk_present && (lk_row == ins_row)))
    else $error("install of an already buffered row");
endmodule

// File: rtl/rtb_lru.sv
module rtb_lru #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] ent_used,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam int AGE_W = IDX_W;

  logic [AGE_W-1:0]   age    [ENTRIES];
  logic [AGE_W-1:0]   nx_age [ENTRIES];
  logic [AGE_W-1:0]   touched_age;
  logic [ENTRIES-1:0] is_mru;

  assign touched_age = age[touch_idx];

  // ages form a permutation; 0 is the most recent, ENTRIES-1 the oldest
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      nx_age[e] = age[e];
      if (touch_en) begin
        if (touch_idx == IDX_W'(e))      nx_age[e] = '0;
        else if (age[e] < touched_age)   nx_age[e] = age[e] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!found && !ent_used[e]) begin
        victim_idx = IDX_W'(e);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (age[e] == AGE_W'(ENTRIES - 1)) victim_idx = IDX_W'(e);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) age[e] <= AGE_W'(e);
    end else if (touch_en) begin
      for (int e = 0; e < ENTRIES; e++) age[e] <= nx_age[e];
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_mru
    assign is_mru[e] = (age[e] == '0);
  end

  // R6/R7: exactly one entry is the most recent at any time
  p_single_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_mru) == 1)
    else $error("recency order broken");

  // R7: a touched entry is the most recent one afterwards
  p_touch_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> is_mru[$past(touch_idx)])
    else $error("touched entry not most recent");
endmodule

// File: rtl/rtb_ctrl.sv
module rtb_ctrl
  import rtb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ROW_W   = 12,
  parameter int TAG_W   = 10,
  parameter int BLKS    = 3,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int BLK_W   = (BLKS > 1) ? $clog2(BLKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  input  logic             lk_present,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             lk_hit,
  input  logic [BLK_W-1:0] lk_blk,
  input  logic             meta_ret_valid,
  input  logic             ret_hit,
  input  logic [BLK_W-1:0] ret_blk,
  input  logic [IDX_W-1:0] victim_idx,
  output logic [TAG_W-1:0] pend_tag,
  output logic             meta_rd_valid,
  output logic [ROW_W-1:0] meta_rd_row,
  output logic             ins_en,
  output logic [IDX_W-1:0] ins_idx,
  output logic             touch_en,
  output logic [IDX_W-1:0] touch_idx,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [BLK_W-1:0] rsp_blk,
  output logic             rsp_fetched
);
  rtb_state_e       st, st_nx;
  logic [ROW_W-1:0] pend_row;
  logic             accept, pend_we;
  logic             rsp_valid_nx, rsp_hit_nx, rsp_fetched_nx;
  logic [BLK_W-1:0] rsp_blk_nx;

  assign req_ready     = (st == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign meta_rd_valid = (st == ST_FETCH);
  assign meta_rd_row   = pend_row;

  always_comb begin
    st_nx          = st;
    pend_we        = 1'b0;
    ins_en         = 1'b0;
    ins_idx        = victim_idx;
    touch_en       = 1'b0;
    touch_idx      = lk_idx;
    rsp_valid_nx   = 1'b0;
    rsp_hit_nx     = 1'b0;
    rsp_blk_nx     = '0;
    rsp_fetched_nx = 1'b0;
    case (st)
      ST_IDLE: begin
        if (accept) begin
          if (lk_present) begin
            touch_en     = 1'b1;
            rsp_valid_nx = 1'b1;
            rsp_hit_nx   = lk_hit;
            rsp_blk_nx   = lk_hit ? lk_blk : '0;
          end else begin
            pend_we = 1'b1;
            st_nx   = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (meta_ret_valid) begin
          ins_en         = 1'b1;
          touch_en       = 1'b1;
          touch_idx      = victim_idx;
          rsp_valid_nx   = 1'b1;
          rsp_hit_nx     = ret_hit;
          rsp_blk_nx     = ret_hit ? ret_blk : '0;
          rsp_fetched_nx = 1'b1;
          st_nx          = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      st        <= st_nx;
      rsp_valid <= rsp_valid_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_we) begin
      pend_row <= req_row;
      pend_tag <= req_tag;
    end
    if (rsp_valid_nx) begin
      rsp_hit     <= rsp_hit_nx;
      rsp_blk     <= rsp_blk_nx;
      rsp_fetched <= rsp_fetched_nx;
    end
  end

  // R4: no new lookup while a metadata read is open
  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meta_rd_valid |-> !req_ready)
    else $error("lookup accepted during fetch");

  // R4: the read request is held until the tags come back
  p_rd_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_rd_valid && !meta_ret_valid) |=> (meta_rd_valid && $stable(meta_rd_row)))
    else $error("metadata read dropped or changed");

  // R4: an absent row opens a fetch and gives no immediate answer
  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lk_present) |=> (meta_rd_valid && !rsp_valid))
    else $error("absent row did not start a fetch");

  // R2: a buffered row is answered next cycle with no fetch
  p_fast_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_present) |=> (rsp_valid && !rsp_fetched && !meta_rd_valid))
    else $error("buffered row not answered at once");

  // R5: returned tags give a fetched response next cycle
  p_ret_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_rd_valid && meta_ret_valid) |=> (rsp_valid && rsp_fetched && req_ready))
    else $error("return not answered");

  // R3: block index is in range on a hit and zero on a miss
  p_blk_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ? (int'(rsp_blk) < BLKS) : (rsp_blk == '0)))
    else $error("bad block index");
endmodule

// File: rtl/row_tag_buffer.sv
module row_tag_buffer #(
  parameter int ENTRIES = 8,
  parameter int ROW_W   = 12,
  parameter int TAG_W   = 10,
  parameter int BLKS    = 3,
  parameter int BLK_W   = (BLKS > 1) ? $clog2(BLKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [TAG_W-1:0]      req_tag,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [BLK_W-1:0]      rsp_blk,
  output logic                  rsp_fetched,
  output logic                  meta_rd_valid,
  output logic [ROW_W-1:0]      meta_rd_row,
  input  logic                  meta_ret_valid,
  input  logic [BLKS*TAG_W-1:0] meta_ret_tags,
  input  logic [BLKS-1:0]       meta_ret_vld,
  input  logic                  upd_valid,
  input  logic [ROW_W-1:0]      upd_row,
  input  logic [BLK_W-1:0]      upd_blk,
  input  logic [TAG_W-1:0]      upd_tag,
  input  logic                  upd_set
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic                  lk_present, lk_hit, ret_hit;
  logic [IDX_W-1:0]      lk_idx, victim_idx, ins_idx, touch_idx;
  logic [BLKS*TAG_W-1:0] lk_tags;
  logic [BLKS-1:0]       lk_vld;
  logic [BLK_W-1:0]      lk_blk, ret_blk;
  logic [TAG_W-1:0]      pend_tag;
  logic                  ins_en, touch_en;
  logic [ENTRIES-1:0]    ent_used;

  rtb_entry_array #(
    .ENTRIES(ENTRIES), .ROW_W(ROW_W), .TAG_W(TAG_W), .BLKS(BLKS),
    .IDX_W(IDX_W), .BLK_W(BLK_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .lk_row(req_row), .lk_present(lk_present), .lk_idx(lk_idx),
    .lk_tags(lk_tags), .lk_vld(lk_vld),
    .ins_en(ins_en), .ins_idx(ins_idx), .ins_row(meta_rd_row),
    .ins_tags(meta_ret_tags), .ins_vld(meta_ret_vld),
    .upd_en(upd_valid), .upd_row(upd_row), .upd_blk(upd_blk),
    .upd_tag(upd_tag), .upd_set(upd_set),
    .ent_used(ent_used)
  );

  rtb_match #(.TAG_W(TAG_W), .BLKS(BLKS), .BLK_W(BLK_W)) u_match_buf (
    .tags(lk_tags), .vld(lk_vld), .key(req_tag), .hit(lk_hit), .blk(lk_blk)
  );

  rtb_match #(.TAG_W(TAG_W), .BLKS(BLKS), .BLK_W(BLK_W)) u_match_ret (
    .tags(meta_ret_tags), .vld(meta_ret_vld), .key(pend_tag),
    .hit(ret_hit), .blk(ret_blk)
  );

  rtb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .ent_used(ent_used), .victim_idx(victim_idx)
  );

  rtb_ctrl #(
    .ENTRIES(ENTRIES), .ROW_W(ROW_W), .TAG_W(TAG_W), .BLKS(BLKS),
    .IDX_W(IDX_W), .BLK_W(BLK_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_row(req_row), .req_tag(req_tag),
    .req_ready(req_ready),
    .lk_present(lk_present), .lk_idx(lk_idx), .lk_hit(lk_hit), .lk_blk(lk_blk),
    .meta_ret_valid(meta_ret_valid), .ret_hit(ret_hit), .ret_blk(ret_blk),
    .victim_idx(victim_idx), .pend_tag(pend_tag),
    .meta_rd_valid(meta_rd_valid), .meta_rd_row(meta_rd_row),
    .ins_en(ins_en), .ins_idx(ins_idx),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_blk(rsp_blk),
    .rsp_fetched(rsp_fetched)
  );
endmodule

// File: tb/test_row_tag_buffer.sv
module test_row_tag_buffer;
  localparam int ENT   = 8;
  localparam int ROW_W = 12;
  localparam int TAG_W = 10;
  localparam int BLKS  = 3;
  localparam int BLK_W = 2;
  localparam int NROWS = 16;

  logic                  clk, rst_n;
  logic                  req_valid, req_ready;
  logic [ROW_W-1:0]      req_row;
  logic [TAG_W-1:0]      req_tag;
  logic                  rsp_valid, rsp_hit, rsp_fetched;
  logic [BLK_W-1:0]      rsp_blk;
  logic                  meta_rd_valid;
  logic [ROW_W-1:0]      meta_rd_row;
  logic                  meta_ret_valid;
  logic [BLKS*TAG_W-1:0] meta_ret_tags;
  logic [BLKS-1:0]       meta_ret_vld;
  logic                  upd_valid, upd_set;
  logic [ROW_W-1:0]      upd_row;
  logic [BLK_W-1:0]      upd_blk;
  logic [TAG_W-1:0]      upd_tag;

  row_tag_buffer #(.ENTRIES(ENT), .ROW_W(ROW_W), .TAG_W(TAG_W), .BLKS(BLKS))
  i_row_tag_buffer (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  typedef struct {
    int   row;
    logic hit;
    int   blk;
    logic fetched;
  } exp_t;
  exp_t  sb[$];
  string sb_note[$];

  logic [TAG_W-1:0] mem_tag [NROWS][BLKS];
  logic             mem_v   [NROWS][BLKS];
  logic [TAG_W-1:0] buf_tag [NROWS][BLKS];
  logic             buf_v   [NROWS][BLKS];
  int               lru_q[$];

  task automatic check(input bit ok, input string note, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s", note, msg);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // driver: computes the expected answer from the model and queues it
  task automatic lookup(input int row, input int tag, input string note);
    exp_t e;
    int   pos;
    while (!req_ready) cyc();
    pos = -1;
    foreach (lru_q[i]) if (lru_q[i] == row) pos = i;
    if (pos >= 0) begin
      e.fetched = 1'b0;
      lru_q.delete(pos);
    end else begin
      e.fetched = 1'b1;
      if (lru_q.size() == ENT) void'(lru_q.pop_back());
      for (int b = 0; b < BLKS; b++) begin
        buf_tag[row][b] = mem_tag[row][b];
        buf_v[row][b]   = mem_v[row][b];
      end
    end
    lru_q.push_front(row);
    e.row = row;
    e.hit = 1'b0;
    e.blk = 0;
    for (int b = BLKS - 1; b >= 0; b--) begin
      if (buf_v[row][b] && buf_tag[row][b] == TAG_W'(tag)) begin
        e.hit = 1'b1;
        e.blk = b;
      end
    end
    sb.push_back(e);
    sb_note.push_back(note);
    req_valid = 1'b1;
    req_row   = ROW_W'(row);
    req_tag   = TAG_W'(tag);
    cyc();
    req_valid = 1'b0;
  endtask

  task automatic update(input int row, input int blk, input int tag,
                        input bit set, input bit to_mem);
    bit buffered;
    while (sb.size() != 0 || !req_ready) cyc();
    buffered = 0;
    foreach (lru_q[i]) if (lru_q[i] == row) buffered = 1;
    if (buffered) begin
      if (set) buf_tag[row][blk] = TAG_W'(tag);
      buf_v[row][blk] = set;
    end
    if (to_mem) begin
      if (set) mem_tag[row][blk] = TAG_W'(tag);
      mem_v[row][blk] = set;
    end
    upd_valid = 1'b1;
    upd_row   = ROW_W'(row);
    upd_blk   = BLK_W'(blk);
    upd_tag   = TAG_W'(tag);
    upd_set   = set;
    cyc();
    upd_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "response with nothing expected");
      end else begin
        exp_t  e;
        string n;
        e = sb.pop_front();
        n = sb_note.pop_front();
        check(rsp_hit === e.hit && rsp_blk === BLK_W'(e.blk) && rsp_fetched === e.fetched,
              n, $sformatf("row %0d act hit=%b blk=%0d fetched=%b exp hit=%b blk=%0d fetched=%b",
                           e.row, rsp_hit, rsp_blk, rsp_fetched, e.hit, e.blk, e.fetched));
      end
    end
  end

  // memory responder: serves metadata reads with varying latency
  initial begin
    meta_ret_valid = 1'b0;
    meta_ret_tags  = '0;
    meta_ret_vld   = '0;
    forever begin
      @(negedge clk);
      if (rst_n && meta_rd_valid) begin
        int r;
        r = int'(meta_rd_row);
        check(sb.size() > 0 && sb[0].fetched && sb[0].row == r, "R4",
              $sformatf("read row act=%0d exp=%0d", r, (sb.size() > 0) ? sb[0].row : -1));
        check(req_ready == 1'b0, "R4", $sformatf("req_ready act=%b exp=0", req_ready));
        repeat (1 + (r % 3)) @(negedge clk);
        @(posedge clk);
        #1;
        meta_ret_valid = 1'b1;
        for (int b = 0; b < BLKS; b++) begin
          meta_ret_tags[b*TAG_W +: TAG_W] = mem_tag[r % NROWS][b];
          meta_ret_vld[b] = mem_v[r % NROWS][b];
        end
        cyc();
        meta_ret_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R1", "watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    req_valid = 0; req_row = '0; req_tag = '0;
    upd_valid = 0; upd_row = '0; upd_blk = '0; upd_tag = '0; upd_set = 0;
    for (int r = 0; r < NROWS; r++) begin
      for (int b = 0; b < BLKS; b++) begin
        mem_tag[r][b] = TAG_W'(r * 37 + b * 11 + 5);
        mem_v[r][b]   = 1'b1;
        buf_tag[r][b] = '0;
        buf_v[r][b]   = 1'b0;
      end
    end
    mem_tag[2][1] = 10'd77;   // repeated tag inside one row
    mem_tag[2][2] = 10'd77;
    mem_v[3][1]   = 1'b0;     // invalid slot

    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    @(negedge clk);
    // R1: reset state
    check(req_ready === 1'b1 && rsp_valid === 1'b0 && meta_rd_valid === 1'b0, "R1",
          $sformatf("ready=%b rsp=%b rd=%b exp 1 0 0", req_ready, rsp_valid, meta_rd_valid));
    cyc();

    lookup(1, 1*37 + 11 + 5, "R1/R5/R10 first lookup fetches");
    lookup(1, 1*37 + 5, "R2 buffered hit");
    lookup(1, 1000, "R3 buffered miss");
    lookup(2, 77, "R3 lowest slot of repeated tag");
    lookup(3, 3*37 + 11 + 5, "R10 invalid slot never hits");
    for (int r = 4; r <= 8; r++) lookup(r, r * 37 + 22 + 5, "R5 fill buffer");
    lookup(1, 1*37 + 5, "R7 refresh oldest row");
    lookup(9, 9*37 + 5, "R6 ninth row evicts LRU");
    lookup(1, 1*37 + 5, "R7 refreshed row kept");
    lookup(2, 79 % 1024, "R6 evicted row refetched");

    update(1, 2, 500, 1'b1, 1'b1);
    lookup(1, 500, "R8 fill on buffered row");
    update(1, 0, 0, 1'b0, 1'b1);
    lookup(1, 1*37 + 5, "R8 eviction on buffered row");

    update(14, 0, 600, 1'b1, 1'b0);
    update(14, 1, 0, 1'b0, 1'b0);
    lookup(14, 600, "R9 update to absent row ignored");
    lookup(14, 14*37 + 11 + 5, "R9 returned tags used");
    lookup(9, 9*37 + 5, "R9 other rows untouched");

    lfsr = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      int r, t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = int'(lfsr[3:0]) % 12;
      t = lfsr[4] ? int'(mem_tag[r][int'(lfsr[6:5]) % BLKS]) : int'(lfsr[15:6]);
      if (i % 9 == 8)
        update(r, int'(lfsr[8:7]) % BLKS, int'(lfsr[15:6]), lfsr[9], 1'b1);
      lookup(r, t, "R3/R6/R7 mixed traffic");
    end

    while (sb.size() != 0) cyc();
    repeat (4) cyc();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule